// File: doc/BRIEF.md
# Sector Erase Accumulation Timer

This block sits between a command decoder and an erase engine in a flash controller. It gathers sector-erase requests into a pending bitmap. The first sector-erase command opens an acceptance window, and each further sector-erase command adds its sector and starts the window again at full length. When a complete window passes with no new sector command, the block closes the window, raises its timeout flag and sends a single start pulse to the erase engine. The engine then works on the collected bitmap.

A chip-erase command skips the window. It marks every sector and starts the erase at once. While an erase runs, the block drops every command except erase suspend, which it forwards as a one-cycle request. An erase-done indication from the engine clears the bitmap and returns the block to idle.

The window length is a runtime input counted in clock cycles. A value of zero is treated as one cycle.

Top module: `erase_gather_timer`

## Requirements
- R1: After a synchronous reset, `sector_map` is all zeros and `window_closed`, `erase_start` and `suspend_req` are 0.
- R2: A command with `cmd_code` = 1 (sector erase) accepted in idle sets bit `cmd_sector` of `sector_map` (bit i stands for sector i) on the next clock edge. `window_closed` stays 0.
- R3: If no further sector command arrives, `erase_start` is high for exactly one cycle and `window_closed` rises to 1 at the same edge. That edge is W edges after the edge that accepted the last sector command, where W = `win_len`, or 1 when `win_len` is 0.
- R4: A sector-erase command accepted while the window is open ORs its sector into `sector_map` and restarts the full window of W cycles.
- R5: A sector-erase command naming a sector already in `sector_map` leaves the map unchanged but still restarts the window.
- R6: A command with `cmd_code` = 2 (chip erase), accepted in idle or while the window is open, sets every bit of `sector_map`. At the next edge it drives `window_closed` to 1 and `erase_start` high for one cycle.
- R7: While erasing (`window_closed` = 1), sector-erase, chip-erase and other commands change neither `sector_map` nor `window_closed`, and they raise no `erase_start`.
- R8: A command with `cmd_code` = 3 (erase suspend) accepted while erasing drives `suspend_req` high for exactly the next cycle. Outside erasing it is ignored.
- R9: `erase_done` while erasing clears `sector_map` and returns `window_closed` to 0 at the next edge. Outside erasing it has no effect.
- R10: A command with `cmd_code` = 0 (other) neither changes `sector_map` nor restarts the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_code | input | 2 | 0 other, 1 sector erase, 2 chip erase, 3 erase suspend |
| cmd_sector | input | SEC_W | Sector index for a sector-erase command |
| win_len | input | WIN_W | Acceptance window length in cycles (0 is treated as 1) |
| erase_done | input | 1 | Erase engine finished |
| sector_map | output | NUM_SECTORS | Pending or active erase set, one bit per sector |
| erase_start | output | 1 | One-cycle launch pulse to the erase engine |
| window_closed | output | 1 | Timeout flag: 0 while accepting, 1 while erasing |
| suspend_req | output | 1 | One-cycle forwarded erase-suspend request |

## Verification
The hardest case to reach is a window that restarts after most of it has already run out. In that case the count must reload to the full length rather than carry on from the remaining value. The stimulus reaches it by sending a second sector command one cycle before expiry, both with a long window and with the short window used in the vector table. It then counts exact edges to the pulse. A chip erase that arrives inside an open window, and a repeated sector inside a window, are reached the same way, by sequencing commands cycle by cycle.

// File: rtl/egt_pkg.sv
package egt_pkg;

    typedef enum logic [1:0] {
        CMD_OTHER   = 2'd0,
        CMD_SECTOR  = 2'd1,
        CMD_CHIP    = 2'd2,
        CMD_SUSPEND = 2'd3
    } cmd_code_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_WINDOW = 2'd1,
        PH_ERASE  = 2'd2
    } phase_e;

    typedef struct packed {
        logic sector;
        logic chip;
        logic suspend;
    } cmd_dec_t;

    function automatic logic phase_accepts(input phase_e ph);
        return (ph == PH_IDLE) || (ph == PH_WINDOW);
    endfunction

endpackage

// File: rtl/egt_cmd_decode.sv
module egt_cmd_decode
    import egt_pkg::*;
(
    input  logic       valid,
    input  logic [1:0] code,
    output cmd_dec_t   dec
);
    cmd_code_e code_e;

    always_comb begin
        code_e      = cmd_code_e'(code);
        dec         = '0;
        if (valid) begin
            unique case (code_e)
                CMD_SECTOR:  dec.sector  = 1'b1;
                CMD_CHIP:    dec.chip    = 1'b1;
                CMD_SUSPEND: dec.suspend = 1'b1;
                default:     dec         = '0;
            endcase
        end
    end

    always_comb begin
        assert ($countones(dec) <= 1) else $error("p_single_decode_r10");
    end
endmodule

// File: rtl/egt_window_timer.sv
module egt_window_timer #(
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [WIN_W-1:0] len,
    output logic             expire
);
    localparam logic [WIN_W-1:0] ONE = WIN_W'(1);

    logic [WIN_W-1:0] cnt_q;
    logic [WIN_W-1:0] len_eff;

    assign len_eff = (len == '0) ? ONE : len;
    assign expire  = run && !load && (cnt_q == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len_eff;
        end else if (run && cnt_q > ONE) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    p_reload_full_r4: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == (($past(len) == '0) ? ONE : $past(len))));

    p_count_down_r3: assert property (@(posedge clk) disable iff (rst)
        (run && !load && cnt_q > ONE) |=> (cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/egt_sector_set.sv
module egt_sector_set #(
    parameter int NUM_SECTORS = 16,
    parameter int SEC_W       = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   add,
    input  logic [SEC_W-1:0]       idx,
    input  logic                   fill,
    input  logic                   clear,
    output logic [NUM_SECTORS-1:0] map
);
    for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                bit_q <= 1'b0;
            end else if (fill) begin
                bit_q <= 1'b1;
            end else if (add && idx == SEC_W'(i)) begin
                bit_q <= 1'b1;
            end
        end
        assign map[i] = bit_q;
    end

    p_map_only_grows_r5: assert property (@(posedge clk) disable iff (rst)
        !clear |=> ((map & $past(map)) == $past(map)));

    p_add_sets_bit_r2: assert property (@(posedge clk) disable iff (rst)
        (add && !clear && !fill) |=> ($countones(map ^ $past(map)) <= 1));
endmodule

// File: rtl/erase_gather_timer.sv
module erase_gather_timer
    import egt_pkg::*;
#(
    parameter int NUM_SECTORS = 16,
    parameter int WIN_W       = 16,
    parameter int SEC_W       = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmd_valid,
    input  logic [1:0]             cmd_code,
    input  logic [SEC_W-1:0]       cmd_sector,
    input  logic [WIN_W-1:0]       win_len,
    input  logic                   erase_done,
    output logic [NUM_SECTORS-1:0] sector_map,
    output logic                   erase_start,
    output logic                   window_closed,
    output logic                   suspend_req
);
    localparam logic [NUM_SECTORS-1:0] ALL_SET = {NUM_SECTORS{1'b1}};

    phase_e   phase_q, phase_d;
    cmd_dec_t dec;
    logic     accepting;
    logic     take_sector, take_chip, take_done, take_suspend;
    logic     win_expire;
    logic     start_q, susp_q;

    egt_cmd_decode u_dec (
        .valid (cmd_valid),
        .code  (cmd_code),
        .dec   (dec)
    );

    assign accepting    = phase_accepts(phase_q);
    assign take_sector  = accepting && dec.sector;
    assign take_chip    = accepting && dec.chip;
    assign take_suspend = (phase_q == PH_ERASE) && dec.suspend;
    assign take_done    = (phase_q == PH_ERASE) && erase_done;

    egt_window_timer #(.WIN_W(WIN_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (take_sector && !take_chip),
        .run    (phase_q == PH_WINDOW),
        .len    (win_len),
        .expire (win_expire)
    );

    egt_sector_set #(.NUM_SECTORS(NUM_SECTORS), .SEC_W(SEC_W)) u_set (
        .clk   (clk),
        .rst   (rst),
        .add   (take_sector),
        .idx   (cmd_sector),
        .fill  (take_chip),
        .clear (take_done),
        .map   (sector_map)
    );

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (take_chip)        phase_d = PH_ERASE;
                else if (take_sector) phase_d = PH_WINDOW;
            end
            PH_WINDOW: begin
                if (take_chip || win_expire) phase_d = PH_ERASE;
            end
            PH_ERASE: begin
                if (take_done) phase_d = PH_IDLE;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            start_q <= 1'b0;
            susp_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            start_q <= take_chip || win_expire;
            susp_q  <= take_suspend;
        end
    end

    assign erase_start   = start_q;
    assign suspend_req   = susp_q;
    assign window_closed = (phase_q == PH_ERASE);

    p_start_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
        erase_start |=> !erase_start);

    p_start_with_flag_r3: assert property (@(posedge clk) disable iff (rst)
        erase_start |-> (window_closed && !$past(window_closed)));

    p_chip_fills_r6: assert property (@(posedge clk) disable iff (rst)
        take_chip |=> (sector_map == ALL_SET && erase_start));

    p_erase_freezes_map_r7: assert property (@(posedge clk) disable iff (rst)
        (window_closed && !erase_done) |=> ($stable(sector_map) && window_closed && !erase_start));

    p_suspend_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        suspend_req |-> $past(window_closed));

    p_done_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (window_closed && erase_done) |=> (sector_map == '0 && !window_closed));
endmodule

// File: tb/erase_gather_timer_bench.sv
`timescale 1ns/1ps
module erase_gather_timer_bench;
    localparam int NS = 16;
    localparam int WW = 16;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          cmd_valid;
    logic [1:0]    cmd_code;
    logic [SW-1:0] cmd_sector;
    logic [WW-1:0] win_len;
    logic          erase_done;
    logic [NS-1:0] sector_map;
    logic          erase_start, window_closed, suspend_req;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    erase_gather_timer #(.NUM_SECTORS(NS), .WIN_W(WW)) u_erase_gather_timer (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_sector(cmd_sector), .win_len(win_len), .erase_done(erase_done),
        .sector_map(sector_map), .erase_start(erase_start),
        .window_closed(window_closed), .suspend_req(suspend_req)
    );

    // valid, code, sector, done | map, flag, start, susp ; window = 3
    localparam int NV = 25;
    localparam logic [26:0] VEC [NV] = '{
        {1'b1,2'd1,4'd2,1'b0, 16'h0004,1'b0,1'b0,1'b0}, // R2 open window
        {1'b0,2'd0,4'd0,1'b0, 16'h0004,1'b0,1'b0,1'b0},
        {1'b1,2'd1,4'd5,1'b0, 16'h0024,1'b0,1'b0,1'b0}, // R4 add and restart
        {1'b0,2'd0,4'd0,1'b0, 16'h0024,1'b0,1'b0,1'b0},
        {1'b0,2'd0,4'd0,1'b0, 16'h0024,1'b0,1'b0,1'b0},
        {1'b0,2'd0,4'd0,1'b0, 16'h0024,1'b1,1'b1,1'b0}, // R3 expiry
        {1'b1,2'd1,4'd7,1'b0, 16'h0024,1'b1,1'b0,1'b0}, // R7 sector ignored
        {1'b1,2'd2,4'd0,1'b0, 16'h0024,1'b1,1'b0,1'b0}, // R7 chip ignored
        {1'b1,2'd3,4'd0,1'b0, 16'h0024,1'b1,1'b0,1'b1}, // R8 suspend
        {1'b0,2'd0,4'd0,1'b0, 16'h0024,1'b1,1'b0,1'b0},
        {1'b0,2'd0,4'd0,1'b1, 16'h0000,1'b0,1'b0,1'b0}, // R9 done
        {1'b1,2'd3,4'd0,1'b0, 16'h0000,1'b0,1'b0,1'b0}, // R8 idle suspend
        {1'b0,2'd0,4'd0,1'b1, 16'h0000,1'b0,1'b0,1'b0}, // R9 idle done
        {1'b1,2'd1,4'd5,1'b0, 16'h0020,1'b0,1'b0,1'b0},
        {1'b1,2'd1,4'd5,1'b0, 16'h0020,1'b0,1'b0,1'b0}, // R5 repeat
        {1'b0,2'd0,4'd0,1'b0, 16'h0020,1'b0,1'b0,1'b0},
        {1'b1,2'd0,4'd9,1'b0, 16'h0020,1'b0,1'b0,1'b0}, // R10 other cmd
        {1'b0,2'd0,4'd0,1'b0, 16'h0020,1'b1,1'b1,1'b0}, // R5 R10 expiry
        {1'b0,2'd0,4'd0,1'b1, 16'h0000,1'b0,1'b0,1'b0},
        {1'b1,2'd2,4'd0,1'b0, 16'hFFFF,1'b1,1'b1,1'b0}, // R6 chip in idle
        {1'b0,2'd0,4'd0,1'b0, 16'hFFFF,1'b1,1'b0,1'b0},
        {1'b0,2'd0,4'd0,1'b1, 16'h0000,1'b0,1'b0,1'b0},
        {1'b1,2'd1,4'd0,1'b0, 16'h0001,1'b0,1'b0,1'b0},
        {1'b1,2'd2,4'd3,1'b0, 16'hFFFF,1'b1,1'b1,1'b0}, // R6 chip in window
        {1'b0,2'd0,4'd0,1'b1, 16'h0000,1'b0,1'b0,1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_in();
        cmd_valid = 1'b0; cmd_code = 2'd0; cmd_sector = '0; erase_done = 1'b0;
    endtask

    task automatic send(input logic [1:0] c, input logic [SW-1:0] s);
        cmd_valid = 1'b1; cmd_code = c; cmd_sector = s;
        tick();
        idle_in();
    endtask

    task automatic finish_erase();
        erase_done = 1'b1;
        tick();
        idle_in();
    endtask

    initial begin
        #(200000 * 8);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        win_len = 16'd3;
        idle_in();
        @(negedge clk);
        repeat (3) tick();
        rst = 1'b0;
        chk("R1 map",   32'(sector_map), 32'h0);
        chk("R1 flag",  32'(window_closed), 32'h0);
        chk("R1 start", 32'(erase_start), 32'h0);
        chk("R1 susp",  32'(suspend_req), 32'h0);

        for (int i = 0; i < NV; i++) begin
            cmd_valid  = VEC[i][26];
            cmd_code   = VEC[i][25:24];
            cmd_sector = VEC[i][23:20];
            erase_done = VEC[i][19];
            tick();
            chk($sformatf("vec%0d map R2 R4 R5 R6 R7 R9", i), 32'(sector_map), 32'(VEC[i][18:3]));
            chk($sformatf("vec%0d flag R3 R7 R9", i), 32'(window_closed), 32'(VEC[i][2]));
            chk($sformatf("vec%0d start R3 R6", i), 32'(erase_start), 32'(VEC[i][1]));
            chk($sformatf("vec%0d susp R8", i), 32'(suspend_req), 32'(VEC[i][0]));
        end
        idle_in();

        // R3: zero window behaves as one cycle
        win_len = 16'd0;
        send(2'd1, 4'd9);
        chk("R3 zero-len flag low", 32'(window_closed), 32'h0);
        tick();
        chk("R3 zero-len start", 32'(erase_start), 32'h1);
        chk("R3 zero-len map", 32'(sector_map), 32'h0200);
        finish_erase();

        // R4: long window restarted one cycle before expiry
        win_len = 16'd20;
        send(2'd1, 4'd15);
        repeat (19) tick();
        chk("R4 before expiry", 32'(window_closed), 32'h0);
        send(2'd1, 4'd1);
        repeat (19) tick();
        chk("R4 restart full flag", 32'(window_closed), 32'h0);
        chk("R4 restart full start", 32'(erase_start), 32'h0);
        tick();
        chk("R4 expiry start", 32'(erase_start), 32'h1);
        chk("R4 expiry map", 32'(sector_map), 32'h8002);
        tick();
        chk("R3 pulse single", 32'(erase_start), 32'h0);
        chk("R7 flag held", 32'(window_closed), 32'h1);
        finish_erase();

        // R1: reset in the middle of an open window
        send(2'd1, 4'd4);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R1 midway map", 32'(sector_map), 32'h0);
        chk("R1 midway flag", 32'(window_closed), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule